// File: doc/BRIEF.md
# Sampled Input Glitch Filter

This block cleans up a raw, asynchronous level, such as a timer input channel, an external trigger line or a push-button. It runs entirely on the timer kernel clock. The raw level first passes through a synchroniser. The filter then samples it at a reduced rate, which is built in two steps. A coarse divider of 1, 2 or 4 turns the kernel clock into a sampling reference. A second divider, taken from the filter code, slows that reference further.

A new level reaches the filtered output only after a run of N consecutive samples has shown it. Any pulse shorter than about (N-1) sampling periods therefore disappears, which gives hardware debouncing with no software involvement. Filter code 0 turns the filter off, and the output then tracks the synchronised input on every clock.

Each change of the filtered output also produces a one-cycle rising or falling strobe. Each channel gets its own instance with its own filter code.

Top module: `glitch_filter`

## Requirements
- R1: While `rst_n` is low, `filt_out`, `rise_pulse` and `fall_pulse` are 0. The synchroniser, sample history and run counter clear to 0.
- R2: When `filt_code` is 0, `filt_out` equals the value `raw_in` had at the clock edge three edges earlier. Two edges are for the synchroniser and one is for the output register.
- R3: The sampling period is P = D*S kernel clocks. D is 1, 2 or 4 for `div_sel` values 0, 1 and 2, and the reserved value 3 behaves as 4. S is 2 to the power `filt_code[3:2]`. Samples are taken on rising edges P, 2P, 3P and so on, counted from the first edge after `rst_n` goes high.
- R4: When `filt_code` is nonzero, N = 2*`filt_code[1:0]` + 2. Each sample reads the synchronised input. The run count becomes 1 when the sample differs from the previous sample, and otherwise grows by one, saturating at N. `filt_out` takes the sampled level at the sample where the run count is at least N.
- R5: With `div_sel`=1 and `filt_code`=6 (P=4, N=6), a 16-cycle high pulse never reaches `filt_out`. A 40-cycle high level does reach it.
- R6: `rise_pulse` is high for exactly the one cycle in which `filt_out` has just gone from 0 to 1. `fall_pulse` is high for the one cycle in which it has just gone from 1 to 0. The two are never high together.
- R7: When `filt_code` is nonzero, `filt_out` changes only on a clock edge on which a sample is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer kernel clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| raw_in | input | 1 | Raw asynchronous level to be filtered |
| div_sel | input | 2 | Sampling reference divider select (1, 2, 4, 4) |
| filt_code | input | 4 | Bits 3:2 are the sample-rate exponent and bits 1:0 the run-length select. The value 0 means bypass |
| filt_out | output | 1 | Filtered level |
| rise_pulse | output | 1 | One-cycle strobe on a 0-to-1 change of `filt_out` |
| fall_pulse | output | 1 | One-cycle strobe on a 1-to-0 change of `filt_out` |

## Verification
Every combination of the two configuration inputs is driven with a pseudo-random sequence of level runs lasting from 1 to 32 cycles. Some runs are shorter than the required run of samples and some are longer, so an output that is updated too early is told apart from one that is updated too late. The same sequence also separates the sampling periods from each other: a divider or rate that is off by one step shifts the sample edges and changes which runs pass.

In bypass mode, the sequence pins down the three-cycle latency. A directed short pulse and a directed long level, in the two-step divided configuration, isolate rejection from acceptance. The reserved divider value is compared against the same model as the divide-by-four setting.

// File: rtl/glitch_filter.sv
module glitch_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_in,
  input  logic [1:0] div_sel,
  input  logic [3:0] filt_code,
  output logic       filt_out,
  output logic       rise_pulse,
  output logic       fall_pulse
);
  localparam int PC_W  = 5;
  localparam int RUN_W = 4;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   s_in;
  logic [1:0]             dts_log;
  logic [2:0]             div_log;
  logic [PC_W:0]          period_m1;
  logic [PC_W-1:0]        pc;
  logic                   tick;
  logic [RUN_W-1:0]       n_need, run_cnt, run_nx;
  logic                   last_samp, bypass, next_out;

  assign s_in      = sync_q[SYNC_STAGES-1];
  assign dts_log   = (div_sel == 2'd0) ? 2'd0 : (div_sel == 2'd1) ? 2'd1 : 2'd2;
  assign div_log   = {1'b0, dts_log} + {1'b0, filt_code[3:2]};
  assign period_m1 = (6'd1 << div_log) - 6'd1;
  assign tick      = ({1'b0, pc} >= period_m1);
  assign n_need    = {1'b0, filt_code[1:0], 1'b0} + 4'd2;
  assign bypass    = (filt_code == 4'd0);

  always_comb begin
    if (s_in != last_samp)     run_nx = 4'd1;
    else if (run_cnt >= n_need) run_nx = run_cnt;
    else                        run_nx = run_cnt + 4'd1;
  end

  assign next_out = bypass ? s_in :
                    (tick && run_nx >= n_need) ? s_in : filt_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q     <= '0;
      pc         <= '0;
      run_cnt    <= '0;
      last_samp  <= 1'b0;
      filt_out   <= 1'b0;
      rise_pulse <= 1'b0;
      fall_pulse <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], raw_in};
      pc         <= tick ? '0 : pc + 1'b1;
      filt_out   <= next_out;
      rise_pulse <= next_out & ~filt_out;
      fall_pulse <= ~next_out & filt_out;
      if (tick) begin
        last_samp <= s_in;
        run_cnt   <= run_nx;
      end
    end
  end
endmodule

// File: rtl/glitch_filter_chk.sv
module glitch_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] filt_code,
  input logic       filt_out,
  input logic       rise_pulse,
  input logic       fall_pulse,
  input logic       tick,
  input logic [3:0] run_cnt,
  input logic [3:0] n_need,
  input logic       s_in
);
  p_edges_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_pulse && fall_pulse));

  p_rise_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_out) |-> rise_pulse);

  p_fall_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_out) |-> fall_pulse);

  p_rise_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |-> filt_out);

  p_change_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_code != 4'd0 && $past(filt_code) != 4'd0 && filt_out != $past(filt_out))
      |-> run_cnt >= n_need);

  p_hold_between_samples_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_code != 4'd0 && $past(filt_code) != 4'd0 && !$past(tick))
      |-> filt_out == $past(filt_out));

  p_bypass_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_code == 4'd0 && $past(filt_code) == 4'd0) |-> filt_out == $past(s_in));
endmodule

bind glitch_filter glitch_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .filt_code(filt_code), .filt_out(filt_out),
  .rise_pulse(rise_pulse), .fall_pulse(fall_pulse), .tick(tick),
  .run_cnt(run_cnt), .n_need(n_need), .s_in(s_in)
);

// File: tb/sim_glitch_filter.sv
module sim_glitch_filter;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw_in = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic [3:0] filt_code = 4'd0;
  logic       filt_out, rise_pulse, fall_pulse;

  int total = 0;
  int bad = 0;

  int  m_p, m_n, m_k, m_cnt;
  logic m_q1, m_q2, m_last, m_out, m_rise, m_fall, m_tick;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  glitch_filter u0 (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .div_sel(div_sel),
    .filt_code(filt_code), .filt_out(filt_out),
    .rise_pulse(rise_pulse), .fall_pulse(fall_pulse)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s div_sel=%0d code=%0d act=%0b exp=%0b t=%0t",
               tag, what, div_sel, filt_code, act, exp, $time);
    end
  endtask

  task automatic start(input logic [1:0] ds, input logic [3:0] fc);
    int d;
    @(negedge clk);
    rst_n = 1'b0;
    raw_in = 1'b0;
    div_sel = ds;
    filt_code = fc;
    d = (ds == 2'd0) ? 1 : (ds == 2'd1) ? 2 : 4;
    m_p = d * (1 << fc[3:2]);
    m_n = 2 * int'(fc[1:0]) + 2;
    m_k = 0; m_cnt = 0;
    m_q1 = 0; m_q2 = 0; m_last = 0; m_out = 0; m_rise = 0; m_fall = 0; m_tick = 0;
    repeat (2) @(negedge clk);
    check("R1", "reset out", filt_out, 1'b0);
    check("R1", "reset rise", rise_pulse, 1'b0);
    check("R1", "reset fall", fall_pulse, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic cyc(input logic v);
    logic nout;
    string tag;
    raw_in = v;
    m_tick = ((m_k % m_p) == m_p - 1);
    nout = m_out;
    if (filt_code == 4'd0) nout = m_q2;
    if (m_tick) begin
      if (m_q2 != m_last) m_cnt = 1;
      else if (m_cnt < m_n) m_cnt = m_cnt + 1;
      m_last = m_q2;
      if (filt_code != 4'd0 && m_cnt >= m_n) nout = m_q2;
    end
    m_rise = nout & ~m_out;
    m_fall = ~nout & m_out;
    m_out = nout;
    m_q2 = m_q1;
    m_q1 = v;
    m_k++;
    @(negedge clk);
    if (filt_code == 4'd0) tag = "R2";
    else if (!m_tick) tag = "R7";
    else if (div_sel == 2'd3) tag = "R3";
    else tag = "R4";
    check(tag, "filt_out", filt_out, m_out);
    check("R6", "rise", rise_pulse, m_rise);
    check("R6", "fall", fall_pulse, m_fall);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic lvl;
    int   seen;
    for (int ds = 0; ds < 4; ds++) begin
      for (int fc = 0; fc < 16; fc++) begin
        start(2'(ds), 4'(fc));
        lvl = 1'b0;
        for (int c = 0; c < RUN_CYCLES; ) begin
          int len;
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          len = int'(lfsr[4:0]) + 1;
          lvl = ~lvl;
          for (int j = 0; j < len; j++) cyc(lvl);
          c += len;
        end
      end
    end

    // R5: short pulse rejected, long level accepted
    start(2'd1, 4'd6);
    seen = 0;
    for (int j = 0; j < 30; j++) cyc(1'b0);
    for (int j = 0; j < 16; j++) begin cyc(1'b1); if (filt_out) seen++; end
    for (int j = 0; j < 40; j++) begin cyc(1'b0); if (filt_out) seen++; end
    check("R5", "short pulse passed", logic'(seen != 0), 1'b0);
    for (int j = 0; j < 40; j++) cyc(1'b1);
    check("R5", "long level out", filt_out, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule